// File: doc/BRIEF.md
# Multi-channel sample unpacker

The block takes a dense, interleaved sample stream from a valid/ready stream source and hands it out to a set of parallel channel ports. Each input beat carries `NUM_CH` samples of `SAMPLE_W` bits. Only the channels enabled in a mask receive samples. A disabled channel takes no share of the stream, so the stream packs samples for the enabled channels only.

The consumer side has one read request, `rd_req`, shared by every channel port. Each request asks for one sample on every enabled port. The answer comes one cycle later. `rd_valid` signals that the enabled ports hold their samples in that same cycle. `rd_underflow` signals that too few samples were buffered. Port data is meaningful only in a cycle with `rd_valid`, and only on enabled ports.

Back-pressure rules on the input stream are as follows. A beat transfers on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is a function of internal state only and does not depend on `s_valid`. The block raises `s_ready` only when its buffer holds too few samples to serve the next request. The source may hold `s_valid` high for any length of time.

The enable mask is captured while `rst` is high and held after that. The buffer is empty when reset ends.

Top module: `sample_unpacker`

## Requirements
- R1: In the first cycle after reset, `rd_valid` and `rd_underflow` are low. If at least one channel is enabled, `s_ready` is high because the buffer is empty.
- R2: `en_mask` is sampled only while `rst` is high. A change to `en_mask` after reset has no effect on which ports receive data.
- R3: Let E be the number of enabled channels. Outside reset, `s_ready` is high exactly when the buffer holds fewer than E samples, so an accepted beat never overwrites undelivered samples.
- R4: If `rd_req` is high in a cycle where at least E samples are buffered, `rd_valid` is high in the next cycle and `rd_underflow` is low.
- R5: Samples are used in arrival order. Within a beat, lane 0 (bits `SAMPLE_W-1:0`) comes first, and lane j sits at bits `j*SAMPLE_W +: SAMPLE_W`. A served request gives its E oldest samples to the enabled ports in ascending port index. Port p appears on `rd_data[p*SAMPLE_W +: SAMPLE_W]`.
- R6: If `rd_req` is high in a cycle where fewer than E samples are buffered, `rd_underflow` is high in the next cycle. No sample is used up.
- R7: `rd_valid` and `rd_underflow` are never high together. Neither is high in a cycle that follows a cycle where `rd_req` was low.
- R8: A beat presented while `s_ready` is low is not taken. Its samples never appear on any port.
- R9: If every channel is disabled, `s_ready` stays low and every request is answered with `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures `en_mask` |
| en_mask | input | NUM_CH | Channel enable bits, bit p for port p |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted on this edge when high with `s_valid` |
| s_data | input | NUM_CH*SAMPLE_W | Input beat, lane 0 earliest |
| rd_req | input | 1 | Shared read request for all channel ports |
| rd_valid | output | 1 | Enabled ports hold their samples this cycle |
| rd_underflow | output | 1 | Previous request could not be served |
| rd_data | output | NUM_CH*SAMPLE_W | Channel port samples, port p at `p*SAMPLE_W` |

## Verification
The bench builds the block with `NUM_CH = 4` and `SAMPLE_W = 16`. Four channels are enough to reach a full mask, sparse masks (0101, 1000), a mask of three channels, and the empty mask. With three enabled channels, the groups of samples one request uses cross the edges of four-sample beats, so the shifting buffer and the rank routing are tested on every possible offset. With a single enabled channel, several requests are served from one beat. With the empty mask, the zero-sample request path is tested.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  typedef enum logic [1:0] {
    RESP_IDLE  = 2'd0,
    RESP_DATA  = 2'd1,
    RESP_SHORT = 2'd2
  } resp_e;

  function automatic int ceil_log2(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/unpack_buffer.sv
module unpack_buffer #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  parameter int CW       = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [NUM_CH*SAMPLE_W-1:0] beat,
  input  logic                       pop,
  input  logic [CW-1:0]              take,
  output logic [CW-1:0]              count,
  output logic [NUM_CH*SAMPLE_W-1:0] window
);
  localparam int DEPTH = 2 * NUM_CH;
  localparam logic [CW-1:0] BEAT_N = CW'(NUM_CH);
  localparam logic [CW-1:0] DEPTH_N = CW'(DEPTH);

  logic [SAMPLE_W-1:0] mem     [DEPTH];
  logic [SAMPLE_W-1:0] mem_nxt [DEPTH];
  logic [CW-1:0]       cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    for (int i = 0; i < DEPTH; i++) mem_nxt[i] = mem[i];
    if (pop) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_nxt[i] = '0;
        for (int k = 0; k < DEPTH; k++)
          if (k == i + int'(take)) mem_nxt[i] = mem[k];
      end
      cnt_nxt = cnt_q - take;
    end else if (push) begin
      for (int i = 0; i < DEPTH; i++)
        for (int j = 0; j < NUM_CH; j++)
          if (i == int'(cnt_q) + j) mem_nxt[i] = beat[j*SAMPLE_W +: SAMPLE_W];
      cnt_nxt = cnt_q + BEAT_N;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_nxt[i];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_win
      assign window[g*SAMPLE_W +: SAMPLE_W] = mem[g];
    end
  endgenerate

  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q + BEAT_N <= DEPTH_N)); // R3
  AST_PUSH_POP_APART: assert property (@(posedge clk) disable iff (rst)
    !(push && pop)); // R3
endmodule

// File: rtl/unpack_route.sv
module unpack_route #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  parameter int CW       = 4,
  parameter int RW       = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          en_mask,
  input  logic                       fire,
  input  logic [NUM_CH*SAMPLE_W-1:0] window,
  output logic [CW-1:0]              take,
  output logic [NUM_CH*SAMPLE_W-1:0] ports
);
  logic [NUM_CH-1:0] mask_q;
  logic [RW-1:0]     rank_d [NUM_CH];
  logic [RW-1:0]     rank_q [NUM_CH];
  logic [CW-1:0]     take_d, take_q;
  logic [SAMPLE_W-1:0] port_q [NUM_CH];

  // Rank of port p = number of enabled ports below it; this is the
  // window slot the port reads from. Computed from the raw mask so
  // that the control is ready the cycle reset ends.
  always_comb begin
    take_d = '0;
    for (int p = 0; p < NUM_CH; p++) begin
      rank_d[p] = '0;
      for (int q = 0; q < NUM_CH; q++)
        if (q < p) rank_d[p] = rank_d[p] + RW'(en_mask[q]);
      take_d = take_d + CW'(en_mask[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= en_mask;
      take_q <= take_d;
      for (int p = 0; p < NUM_CH; p++) rank_q[p] <= rank_d[p];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) port_q[g] <= '0;
        else if (fire)
          port_q[g] <= mask_q[g] ? window[int'(rank_q[g])*SAMPLE_W +: SAMPLE_W] : '0;
      end
      assign ports[g*SAMPLE_W +: SAMPLE_W] = port_q[g];
    end
  endgenerate

  assign take = take_q;

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mask_q)); // R2
endmodule

// File: rtl/unpack_resp.sv
module unpack_resp
  import unpack_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic enough,
  output logic fire,
  output logic rd_valid,
  output logic rd_underflow
);
  resp_e state_q, state_d;

  always_comb begin
    if (!rd_req)     state_d = RESP_IDLE;
    else if (enough) state_d = RESP_DATA;
    else             state_d = RESP_SHORT;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= RESP_IDLE;
    else     state_q <= state_d;
  end

  assign fire         = (state_d == RESP_DATA);
  assign rd_valid     = (state_q == RESP_DATA);
  assign rd_underflow = (state_q == RESP_SHORT);

  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_underflow)); // R7
  AST_NO_UNASKED_RESP: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !(rd_valid || rd_underflow)); // R7
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (rd_valid || rd_underflow)); // R4
endmodule

// File: rtl/sample_unpacker.sv
module sample_unpacker #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          en_mask,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [NUM_CH*SAMPLE_W-1:0] s_data,
  input  logic                       rd_req,
  output logic                       rd_valid,
  output logic                       rd_underflow,
  output logic [NUM_CH*SAMPLE_W-1:0] rd_data
);
  localparam int CW = unpack_pkg::ceil_log2(2 * NUM_CH + 1);
  localparam int RW = unpack_pkg::ceil_log2(NUM_CH);

  logic [CW-1:0]              count, take;
  logic [NUM_CH*SAMPLE_W-1:0] window;
  logic                       push, fire, enough;

  assign enough  = (count >= take);
  assign s_ready = !rst && (count < take);
  assign push    = s_valid && s_ready;

  unpack_buffer #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CW(CW)) u_buf (
    .clk(clk), .rst(rst), .push(push), .beat(s_data),
    .pop(fire), .take(take), .count(count), .window(window)
  );

  unpack_route #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CW(CW), .RW(RW)) u_route (
    .clk(clk), .rst(rst), .en_mask(en_mask), .fire(fire),
    .window(window), .take(take), .ports(rd_data)
  );

  unpack_resp u_resp (
    .clk(clk), .rst(rst), .rd_req(rd_req), .enough(enough),
    .fire(fire), .rd_valid(rd_valid), .rd_underflow(rd_underflow)
  );

  AST_SHORT_KEEPS_STOCK: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !enough) |=> (count >= $past(count))); // R6
endmodule

// File: tb/tb_sample_unpacker.sv
`timescale 1ns/1ps
module tb_sample_unpacker;
  localparam int NCH = 4;
  localparam int W   = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] en_mask = '0;
  logic           s_valid = 1'b0;
  logic           s_ready;
  logic [NCH*W-1:0] s_data = '0;
  logic           rd_req = 1'b0;
  logic           rd_valid, rd_underflow;
  logic [NCH*W-1:0] rd_data;

  always #2 clk = ~clk;

  sample_unpacker #(.NUM_CH(NCH), .SAMPLE_W(W)) dut (
    .clk(clk), .rst(rst), .en_mask(en_mask), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_underflow(rd_underflow), .rd_data(rd_data)
  );

  typedef struct {
    int           kind;   // 0 none, 1 data, 2 underflow
    logic [NCH*W-1:0] data;
  } exp_t;

  exp_t           expq[$];
  logic [W-1:0]   sq[$];
  logic [NCH-1:0] cur_mask;
  int             e_cnt;
  int             seq = 1;
  int             checks = 0;
  int             fails  = 0;
  bit             mon_on = 0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Monitor: compares each cycle's response against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && expq.size() > 0) begin
        exp_t it;
        it = expq.pop_front();
        checks++;
        if (it.kind == 0) begin
          if (rd_valid || rd_underflow) begin
            fails++;
            $display("FAIL R7: unrequested response valid=%0b under=%0b expected 0/0", rd_valid, rd_underflow);
          end
        end else if (it.kind == 2) begin
          if (!rd_underflow || rd_valid) begin
            fails++;
            $display("FAIL R6: valid=%0b under=%0b expected 0/1", rd_valid, rd_underflow);
          end
        end else begin
          if (!rd_valid || rd_underflow) begin
            fails++;
            $display("FAIL R4/R9: valid=%0b under=%0b expected 1/0", rd_valid, rd_underflow);
          end
          for (int p = 0; p < NCH; p++) begin
            if (cur_mask[p]) begin
              checks++;
              if (rd_data[p*W +: W] !== it.data[p*W +: W]) begin
                fails++;
                $display("FAIL R5: port %0d got %h expected %h", p, rd_data[p*W +: W], it.data[p*W +: W]);
              end
            end
          end
        end
      end
    end
  end

  // Driver: one cycle of stimulus, expected response queued
  task automatic step(input bit v, input bit req);
    exp_t it;
    bit   rdy;
    @(negedge clk);
    rdy = s_ready;
    checks++;
    if (rdy !== (sq.size() < e_cnt)) begin
      fails++;
      $display("FAIL R3: s_ready=%0b expected %0b (held %0d, need %0d)", rdy, (sq.size() < e_cnt), sq.size(), e_cnt);
    end
    s_valid = v;
    rd_req  = req;
    for (int j = 0; j < NCH; j++)
      s_data[j*W +: W] = rdy ? W'(seq + j) : (16'hBAD0 | W'(j)); // R8 poison
    it.kind = 0;
    it.data = '0;
    if (req) begin
      if (sq.size() >= e_cnt) begin
        it.kind = 1;
        for (int p = 0; p < NCH; p++)
          if (cur_mask[p]) it.data[p*W +: W] = sq.pop_front();
      end else begin
        it.kind = 2;
      end
    end
    expq.push_back(it);
    if (v && rdy) begin
      for (int j = 0; j < NCH; j++) sq.push_back(W'(seq + j));
      seq += NCH;
    end
  endtask

  task automatic do_reset(input logic [NCH-1:0] m);
    mon_on = 0;
    @(negedge clk);
    rst = 1'b1; en_mask = m; s_valid = 1'b0; rd_req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    en_mask = ~m; // R2: later mask changes must be ignored
    sq.delete();
    expq.delete();
    cur_mask = m;
    e_cnt = $countones(m);
    #0.5;
    checks++;
    if (rd_valid || rd_underflow || (s_ready !== (e_cnt > 0))) begin
      fails++;
      $display("FAIL R1: valid=%0b under=%0b ready=%0b expected 0/0/%0b", rd_valid, rd_underflow, s_ready, (e_cnt > 0));
    end
    mon_on = 1;
  endtask

  task automatic run_mask(input logic [NCH-1:0] m);
    do_reset(m);
    step(0, 1);                       // R6: request on empty buffer
    step(1, 0);
    for (int i = 0; i < 80; i++)
      step((i % 5) != 3, (i % 3) != 1); // R4/R5/R8 mixed traffic
    for (int i = 0; i < 8; i++) step(1, 1);   // back-to-back R3
    for (int i = 0; i < 12; i++) step(0, 1);  // drain into underflow R6
    step(0, 0);
    step(0, 0);                       // R7 idle
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    run_mask(4'b1111);
    run_mask(4'b0101);
    run_mask(4'b1011);
    run_mask(4'b1000);
    run_mask(4'b0000);                // R9
    mon_on = 0;
    summary();
    $finish;
  end
endmodule